// File: doc/BRIEF.md
# ECC-Driven Page and Group Retirement Tracker

This block sits behind an ECC decoder in a flash controller. Each read-completion report names a block and a page and carries the number of bits the decoder corrected. The block compares that count with a threshold supplied on a port. The threshold is set below the decoder's correction limit: for a 192-bit-per-page capability, a value such as 180. When a report reaches the threshold, the tracker takes a page or a whole page group out of service. The other pages of that flash block stay in use.

Two retirement policies are chosen by a mode input. In page mode only the reported page is retired, recorded in one bit per page. In group mode the pages of a block are sorted into groups by a fixed device-characterization map, which is loaded into a table at reset, and the whole group holding the reported page is marked unhealthy. Each block keeps an 8-bit health marker with one bit per group. Allocation logic queries a block/page pair and gets back, one cycle later, whether that page is usable, its group and the block's marker.

Top module: `ret_tracker`

## Requirements
- R1: After reset every page of every block queries as usable, and every block's marker reads 0x0F: bits 0..3 set for the four groups and bits 7..4 zero.
- R2: In page mode (mode_group=0), a valid report with rpt_corr >= thresh retires that page, so that it queries as unusable.
- R3: A valid report with rpt_corr < thresh changes no page and no marker bit.
- R4: A page-mode retirement leaves every other page and the marker of that block, and all other blocks, unchanged.
- R5: In group mode (mode_group=1), a valid report with rpt_corr >= thresh clears marker bit g of the reported block, where g is the group of the reported page. Every page of group g in that block then queries unusable, and pages of the other groups and other blocks stay usable.
- R6: The group of page p is (p XOR (p >> 4)) mod 4, reported on q_group as a 2-bit value.
- R7: The query outputs are registered. The values after a clock edge describe the address on q_block/q_page at that edge and the state as it stood before that edge. A retirement accepted at one edge is therefore first visible to a query taken at the following edge.
- R8: Retirement is sticky. A later report with a low count does not restore a page or a group, and only reset clears the state, since the block has no other clearing path.
- R9: The comparison is inclusive. A count equal to the threshold retires, including a threshold of 0, which retires on any report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_group | input | 1 | 0 = page retirement, 1 = group retirement |
| thresh | input | 8 | Tolerated corrected-bit threshold |
| rpt_valid | input | 1 | Read-completion report valid |
| rpt_block | input | 4 | Reported block index |
| rpt_page | input | 6 | Reported page index |
| rpt_corr | input | 8 | Bits corrected on that read |
| q_block | input | 4 | Query block index |
| q_page | input | 6 | Query page index |
| q_page_ok | output | 1 | Queried page usable |
| q_group | output | 2 | Group of the queried page |
| q_mark | output | 8 | Health marker of the queried block |

## Verification
A retired bit written to the wrong index shows up as a wrong q_page_ok at two addresses: one that should have been retired and one that should not. That error is visible on the first query taken after the report's edge. A marker bit cleared in the wrong position changes q_mark for every page of the block at once. A wrong entry in the map table shows up as a wrong q_group even before any retirement. The full sweeps over all 1024 addresses after each phase expose each of these faults within one sweep.

// File: rtl/retire_pkg.sv
package retire_pkg;
  // Fixed characterization map: group index of a page within its block.
  function automatic int unsigned grp_of(input int unsigned page, input int unsigned ngroups);
    return (page ^ (page >> 4)) % ngroups;
  endfunction
endpackage

// File: rtl/ret_decide.sv
module ret_decide #(
  parameter int CNT_W = 8
) (
  input  logic             rpt_valid,
  input  logic             mode_group,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] rpt_corr,
  output logic             hit_page,
  output logic             hit_group
);
  logic over;
  always_comb begin
    over      = rpt_valid && (rpt_corr >= thresh);
    hit_page  = over && !mode_group;
    hit_group = over && mode_group;
  end
endmodule

// File: rtl/ret_page_store.sv
module ret_page_store #(
  parameter int NB    = 16,
  parameter int PAGES = 64,
  parameter int BLK_W = 4,
  parameter int PG_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [BLK_W-1:0]   set_blk,
  input  logic [PG_W-1:0]    set_pg,
  output logic [NB*PAGES-1:0] ret_q
);
  always_ff @(posedge clk) begin
    if (rst) ret_q <= '0;
    else if (set_en) ret_q[{set_blk, set_pg}] <= 1'b1;
  end
endmodule

// File: rtl/ret_group_store.sv
module ret_group_store
  import retire_pkg::*;
#(
  parameter int NB     = 16,
  parameter int PAGES  = 64,
  parameter int NGRP   = 4,
  parameter int MARK_W = 8,
  parameter int BLK_W  = 4,
  parameter int PG_W   = 6,
  parameter int GRP_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_en,
  input  logic [BLK_W-1:0]     clr_blk,
  input  logic [PG_W-1:0]      clr_pg,
  input  logic [BLK_W-1:0]     q_blk,
  input  logic [PG_W-1:0]      q_pg,
  output logic [GRP_W-1:0]     q_grp,
  output logic                 q_grp_ok,
  output logic [MARK_W-1:0]    q_row,
  output logic [NB*MARK_W-1:0] mark_q
);
  localparam int MI_W = $clog2(NB * MARK_W);
  localparam logic [MARK_W-1:0] HEALTHY = MARK_W'((1 << NGRP) - 1);

  logic [GRP_W-1:0] map_q [PAGES];
  logic [GRP_W-1:0] clr_grp;
  logic [MI_W-1:0]  clr_idx, q_idx, q_base;

  always_comb begin
    clr_grp  = map_q[clr_pg];
    q_grp    = map_q[q_pg];
    clr_idx  = MI_W'(int'(clr_blk) * MARK_W + int'(clr_grp));
    q_idx    = MI_W'(int'(q_blk) * MARK_W + int'(q_grp));
    q_base   = MI_W'(int'(q_blk) * MARK_W);
    q_grp_ok = mark_q[q_idx];
    q_row    = mark_q[q_base +: MARK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PAGES; p++) map_q[p] <= GRP_W'(grp_of(p, NGRP));
      for (int b = 0; b < NB; b++) mark_q[b*MARK_W +: MARK_W] <= HEALTHY;
    end else if (clr_en) begin
      mark_q[clr_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/ret_tracker.sv
module ret_tracker #(
  parameter int NUM_BLOCKS = 16,
  parameter int PAGES      = 64,
  parameter int NUM_GROUPS = 4,
  parameter int MARK_W     = 8,
  parameter int CNT_W      = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES),
  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_group,
  input  logic [CNT_W-1:0]  thresh,
  input  logic              rpt_valid,
  input  logic [BLK_W-1:0]  rpt_block,
  input  logic [PG_W-1:0]   rpt_page,
  input  logic [CNT_W-1:0]  rpt_corr,
  input  logic [BLK_W-1:0]  q_block,
  input  logic [PG_W-1:0]   q_page,
  output logic              q_page_ok,
  output logic [GRP_W-1:0]  q_group,
  output logic [MARK_W-1:0] q_mark
);
  logic hit_page, hit_group;
  logic [NUM_BLOCKS*PAGES-1:0]  ret_q;
  logic [NUM_BLOCKS*MARK_W-1:0] mark_q;
  logic [GRP_W-1:0]  q_grp_c;
  logic              q_grp_ok_c;
  logic [MARK_W-1:0] q_row_c;

  ret_decide #(.CNT_W(CNT_W)) decide_i (
    .rpt_valid(rpt_valid), .mode_group(mode_group), .thresh(thresh),
    .rpt_corr(rpt_corr), .hit_page(hit_page), .hit_group(hit_group));

  ret_page_store #(.NB(NUM_BLOCKS), .PAGES(PAGES), .BLK_W(BLK_W), .PG_W(PG_W)) pages_i (
    .clk(clk), .rst(rst), .set_en(hit_page), .set_blk(rpt_block),
    .set_pg(rpt_page), .ret_q(ret_q));

  ret_group_store #(.NB(NUM_BLOCKS), .PAGES(PAGES), .NGRP(NUM_GROUPS), .MARK_W(MARK_W),
                    .BLK_W(BLK_W), .PG_W(PG_W), .GRP_W(GRP_W)) groups_i (
    .clk(clk), .rst(rst), .clr_en(hit_group), .clr_blk(rpt_block), .clr_pg(rpt_page),
    .q_blk(q_block), .q_pg(q_page), .q_grp(q_grp_c), .q_grp_ok(q_grp_ok_c),
    .q_row(q_row_c), .mark_q(mark_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      q_page_ok <= 1'b0;
      q_group   <= '0;
      q_mark    <= '0;
    end else begin
      q_page_ok <= !ret_q[{q_block, q_page}] && q_grp_ok_c;
      q_group   <= q_grp_c;
      q_mark    <= q_row_c;
    end
  end
endmodule

// File: rtl/ret_tracker_chk.sv
module ret_tracker_chk #(
  parameter int NB = 16, PAGES = 64, MARK_W = 8, CNT_W = 8, BLK_W = 4, PG_W = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  rpt_valid,
  input logic                  mode_group,
  input logic [CNT_W-1:0]      thresh,
  input logic [CNT_W-1:0]      rpt_corr,
  input logic [BLK_W-1:0]      rpt_block,
  input logic [PG_W-1:0]       rpt_page,
  input logic [NB*PAGES-1:0]   ret_q,
  input logic [NB*MARK_W-1:0]  mark_q
);
  logic [BLK_W+PG_W-1:0] idx;
  assign idx = {rpt_block, rpt_page};

  assert_page_hit_R2: assert property (@(posedge clk) disable iff (rst)
    rpt_valid && !mode_group && (rpt_corr >= thresh) |=> ret_q[$past(idx)]);

  assert_below_no_change_R3: assert property (@(posedge clk) disable iff (rst)
    rpt_valid && (rpt_corr < thresh) |=> (ret_q == $past(ret_q)) && (mark_q == $past(mark_q)));

  assert_group_keeps_pages_R5: assert property (@(posedge clk) disable iff (rst)
    rpt_valid && mode_group |=> ret_q == $past(ret_q));

  assert_pages_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(ret_q) & ~ret_q) == '0);

  assert_marks_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (mark_q & ~$past(mark_q)) == '0);

  assert_idle_no_change_R4: assert property (@(posedge clk) disable iff (rst)
    !rpt_valid |=> (ret_q == $past(ret_q)) && (mark_q == $past(mark_q)));
endmodule

bind ret_tracker ret_tracker_chk #(
  .NB(NUM_BLOCKS), .PAGES(PAGES), .MARK_W(MARK_W), .CNT_W(CNT_W), .BLK_W(BLK_W), .PG_W(PG_W)
) chk_i (
  .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .mode_group(mode_group), .thresh(thresh),
  .rpt_corr(rpt_corr), .rpt_block(rpt_block), .rpt_page(rpt_page),
  .ret_q(ret_q), .mark_q(mark_q));

// File: tb/ret_tracker_tb_top.sv
`timescale 1ns/1ps
module ret_tracker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_group = 1'b0;
  logic [7:0] thresh = 8'd180;
  logic rpt_valid = 1'b0;
  logic [3:0] rpt_block = '0;
  logic [5:0] rpt_page = '0;
  logic [7:0] rpt_corr = '0;
  logic [3:0] q_block = '0;
  logic [5:0] q_page = '0;
  logic q_page_ok;
  logic [1:0] q_group;
  logic [7:0] q_mark;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit ret_m [16][64];
  logic [7:0] mark_m [16];

  always #2 clk = ~clk;

  ret_tracker dut_i (
    .clk(clk), .rst(rst), .mode_group(mode_group), .thresh(thresh),
    .rpt_valid(rpt_valid), .rpt_block(rpt_block), .rpt_page(rpt_page), .rpt_corr(rpt_corr),
    .q_block(q_block), .q_page(q_page), .q_page_ok(q_page_ok), .q_group(q_group), .q_mark(q_mark));

  function automatic int gexp(input int p);
    return (p ^ (p >> 4)) & 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 16; b++) begin
      mark_m[b] = 8'h0F;
      for (int p = 0; p < 64; p++) ret_m[b][p] = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; rpt_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  // Report accepted at the next posedge.
  task automatic report(input int b, input int p, input int c, input bit gm);
    @(negedge clk);
    mode_group = gm; rpt_valid = 1'b1;
    rpt_block = 4'(b); rpt_page = 6'(p); rpt_corr = 8'(c);
    @(posedge clk);
    if (c >= int'(thresh)) begin
      if (gm) mark_m[b][gexp(p)] = 1'b0;
      else ret_m[b][p] = 1'b1;
    end
    @(negedge clk); rpt_valid = 1'b0;
  endtask

  task automatic query(input int b, input int p, input string req);
    bit eok;
    @(negedge clk);
    q_block = 4'(b); q_page = 6'(p);
    @(posedge clk); #1;
    eok = !ret_m[b][p] && mark_m[b][gexp(p)];
    chk(q_page_ok == eok, {req, " ok"}, int'(q_page_ok), int'(eok));
    chk(int'(q_group) == gexp(p), "R6 group", int'(q_group), gexp(p));
    chk(q_mark == mark_m[b], {req, " mark"}, int'(q_mark), int'(mark_m[b]));
  endtask

  task automatic sweep_all(input string req);
    for (int b = 0; b < 16; b++)
      for (int p = 0; p < 64; p++) query(b, p, req);
  endtask

  task automatic sweep_blk(input int b, input string req);
    for (int p = 0; p < 64; p++) query(b, p, req);
  endtask

  initial begin
    do_reset();
    sweep_all("R1");

    // R3 below threshold, R9 equality, R2 retire
    thresh = 8'd180;
    report(3, 10, 179, 1'b0);
    query(3, 10, "R3");
    report(3, 10, 180, 1'b0);
    query(3, 10, "R9");
    report(3, 11, 192, 1'b0);
    report(5, 63, 255, 1'b0);
    query(3, 11, "R2");
    query(5, 63, "R2");
    sweep_blk(3, "R4");
    sweep_blk(5, "R4");
    sweep_blk(4, "R4");

    // R7 timing: report and query at the same edge
    @(negedge clk);
    mode_group = 1'b0; rpt_valid = 1'b1; rpt_block = 4'd7; rpt_page = 6'd0; rpt_corr = 8'd200;
    q_block = 4'd7; q_page = 6'd0;
    @(posedge clk); #1;
    chk(q_page_ok == 1'b1, "R7 same-edge", int'(q_page_ok), 1);
    ret_m[7][0] = 1'b1;
    @(negedge clk); rpt_valid = 1'b0;
    @(posedge clk); #1;
    chk(q_page_ok == 1'b0, "R7 next-edge", int'(q_page_ok), 0);

    // R5 group mode
    report(9, 17, 190, 1'b1);
    sweep_blk(9, "R5");
    sweep_blk(10, "R5");
    report(12, 0, 100, 1'b1);
    sweep_blk(12, "R3");
    report(12, 48, 181, 1'b1);
    report(12, 5, 200, 1'b1);
    sweep_blk(12, "R5");

    // R8 sticky
    report(3, 10, 0, 1'b0);
    query(3, 10, "R8");
    report(9, 17, 0, 1'b1);
    query(9, 17, "R8");

    // R9 threshold zero
    thresh = 8'd0;
    report(14, 33, 0, 1'b0);
    query(14, 33, "R9");
    report(15, 2, 0, 1'b1);
    sweep_blk(15, "R9");
    sweep_all("R8");

    do_reset();
    sweep_all("R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule